// File: doc/BRIEF.md
# Multicast Lookahead Bypass Allocator

This block is the allocation and bypass-control stage for one input port of an on-chip router that carries one-to-many and broadcast traffic. One cycle before a flit reaches the port, a lookahead brings in a destination bitmask with one bit per output port. The block splits that mask into one request per destination port. It ranks those requests above the requests of flits already held at this input. It then decides whether the arriving flit can skip the input buffer altogether.

Bypass happens only when every destination port in the mask is free in the lookahead's cycle. In that case the registered bypass controls steer the arriving flit straight onto the crossbar and links, and the flit is never written into storage. If even one destination is busy, the lookahead keeps no port at all. The flit is then written into a free slot of a four-slot buffer and competes again from the next cycle. A held multicast flit can leave over several cycles. Each slot keeps a mask of the ports it still has to reach and becomes free once that mask is empty. Each output port runs its own round-robin arbiter among the held slots.

Top module: `mcast_bypass_alloc`

## Requirements
- R1: While reset is held, and in the first cycle after it, every output is zero. The slot masks and all round-robin pointers start empty or at zero.
- R2: A lookahead with la_valid high and a nonzero la_mask requests each output port p for which la_mask[p] is 1 (port p is bit p, with 5 ports). When la_valid is low, or when la_mask is zero, the lookahead has no effect: the next cycle shows no bypass, no buffer write and no error.
- R3: Suppose every port the lookahead requests is high in out_avail in the same cycle. Then one cycle later byp_en is 1 and xb_bypass equals the requested mask.
- R4: In a cycle where byp_en is 1, buf_wr is 0. The bypassing flit is never written into the buffer.
- R5: Suppose at least one requested port is low in out_avail. Then one cycle later byp_en and xb_bypass are all zero, so ports the lookahead could have won are released. buf_wr is 1 and buf_wr_slot holds the lowest-numbered slot that was empty in the lookahead's cycle.
- R6: A port that a fully winning lookahead takes in a cycle is not granted to any held slot in that cycle.
- R7: For each port p that is available and not taken by a bypass, the grant goes to the first slot, starting from that port's pointer and counting up with wrap, that still needs p. The pointer then moves to the granted slot plus one, modulo 4. The pointer does not move when no grant is made.
- R8: A grant clears that port from the slot's remaining mask, and the slot becomes free once its mask is empty. A slot written for a lookahead seen in cycle t can first be granted in cycle t+1, and that grant appears at the outputs in cycle t+2.
- R9: Grants appear one cycle after the decision. xb_valid[p] is 1 only if out_avail[p] was 1 in the deciding cycle. For a port serving a held slot, xb_slot[2p+1:2p] holds the slot number in binary. It is zero for a bypass port or an idle port.
- R10: Suppose a lookahead needs buffering while all 4 slots are occupied. Then one cycle later ovf_err is 1, buf_wr is 0, and the flit leaves no slot state behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| la_valid | input | 1 | Lookahead present this cycle |
| la_mask | input | 5 | Destination ports of the lookahead, bit p = port p |
| out_avail | input | 5 | Output ports this input may use this cycle |
| byp_en | output | 1 | Arriving flit bypasses the buffer this cycle |
| xb_bypass | output | 5 | Ports driven by the bypassing flit |
| xb_valid | output | 5 | Ports driven this cycle by bypass or a held slot |
| xb_slot | output | 10 | Per-port held-slot select, 2 bits per port |
| buf_wr | output | 1 | Arriving flit is written into the buffer |
| buf_wr_slot | output | 2 | Slot receiving the arriving flit |
| ovf_err | output | 1 | Flit needed buffering while the buffer was full |

## Verification
A wrong remaining mask inside a slot shows up on xb_valid and xb_slot in the next cycle that port is available. The slot is either granted a port it already reached or is skipped. A stale mask also keeps the slot occupied, so a later buf_wr_slot, or an ovf_err, differs from expectation within a few lookaheads. A round-robin pointer that drifts changes xb_slot as soon as two slots compete for the same port. For that reason the bench compares every registered output against its model on every cycle, using traffic dense enough that slots contend and the buffer fills.

// File: rtl/mcba_pkg.sv
package mcba_pkg;

  // 1 when a nonempty request set is fully covered by the available set
  function automatic logic all_won(input logic [31:0] req, input logic [31:0] avail);
    return (req != 32'd0) && ((req & ~avail) == 32'd0);
  endfunction

  // index of the lowest clear bit among the first n bits, or n when none
  function automatic int lowest_zero(input logic [31:0] v, input int n);
    int res;
    res = n;
    for (int i = n - 1; i >= 0; i--) begin
      if (!v[i]) res = i;
    end
    return res;
  endfunction

  // next round-robin position after idx in a ring of n
  function automatic int ring_next(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/mcba_la_split.sv
module mcba_la_split #(
  parameter int NP = 5
) (
  input  logic          la_valid,
  input  logic [NP-1:0] la_mask,
  input  logic [NP-1:0] out_avail,
  output logic          need,
  output logic          all_win,
  output logic [NP-1:0] la_win_mask,
  output logic [NP-1:0] avail_buf
);
  // one request per destination bit; all must be won for a bypass
  assign need        = la_valid && (la_mask != '0);
  assign all_win     = need && mcba_pkg::all_won(32'(la_mask), 32'(out_avail));
  assign la_win_mask = all_win ? la_mask : '0;
  // ports left over for buffered flits (partial wins are released)
  assign avail_buf   = out_avail & ~la_win_mask;
endmodule

// File: rtl/mcba_rr_arb.sv
module mcba_rr_arb #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic         gnt_any,
  output logic [W-1:0] gnt_idx
);
  logic [W-1:0] ptr_q;

  always_comb begin
    logic [W-1:0] cand;
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int k = 0; k < N; k++) begin
      cand = W'((int'(ptr_q) + k) % N);
      if (!gnt_any && req[cand]) begin
        gnt_any = 1'b1;
        gnt_idx = cand;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr_q <= '0;
    else if (gnt_any) ptr_q <= W'(mcba_pkg::ring_next(int'(gnt_idx), N));
  end

  assert_gnt_has_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_any |-> req[gnt_idx]);
  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_any |=> $stable(ptr_q));
  assert_no_idle_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> gnt_any);
endmodule

// File: rtl/mcba_slot_table.sv
module mcba_slot_table #(
  parameter int NP    = 5,
  parameter int NSLOT = 4,
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSLOT*NP-1:0] clr_flat,
  input  logic                wr_en,
  input  logic [SW-1:0]       wr_slot,
  input  logic [NP-1:0]       wr_mask,
  output logic [NSLOT*NP-1:0] rem_flat,
  output logic [NSLOT-1:0]    slot_valid
);
  genvar s;
  generate
    for (s = 0; s < NSLOT; s++) begin : g_slot
      logic [NP-1:0] rem_q;
      logic [NP-1:0] clr_s;
      assign clr_s = clr_flat[s*NP +: NP];

      always_ff @(posedge clk) begin
        if (!rst_n)                          rem_q <= '0;
        else if (wr_en && (int'(wr_slot) == s)) rem_q <= wr_mask;
        else                                 rem_q <= rem_q & ~clr_s;
      end

      assign rem_flat[s*NP +: NP] = rem_q;
      assign slot_valid[s]        = (rem_q != '0);

      // a grant may only clear a port the slot still needs
      assert_clr_subset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_s & ~rem_q) == '0);
      // an empty mask frees the slot on the following cycle
      assert_free_on_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_q != '0 && (rem_q & ~clr_s) == '0 && !(wr_en && int'(wr_slot) == s))
        |=> !slot_valid[s]);
    end
  endgenerate

  assert_wr_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !slot_valid[wr_slot]);
endmodule

// File: rtl/mcast_bypass_alloc.sv
module mcast_bypass_alloc #(
  parameter int NP    = 5,
  parameter int NSLOT = 4,
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             la_valid,
  input  logic [NP-1:0]    la_mask,
  input  logic [NP-1:0]    out_avail,
  output logic             byp_en,
  output logic [NP-1:0]    xb_bypass,
  output logic [NP-1:0]    xb_valid,
  output logic [NP*SW-1:0] xb_slot,
  output logic             buf_wr,
  output logic [SW-1:0]    buf_wr_slot,
  output logic             ovf_err
);
  // lookahead side
  logic          need, all_win;
  logic [NP-1:0] la_win_mask, avail_buf;

  mcba_la_split #(.NP(NP)) i_split (
    .la_valid    (la_valid),
    .la_mask     (la_mask),
    .out_avail   (out_avail),
    .need        (need),
    .all_win     (all_win),
    .la_win_mask (la_win_mask),
    .avail_buf   (avail_buf)
  );

  // buffer slot state
  logic [NSLOT*NP-1:0] rem_flat, clr_flat;
  logic [NSLOT-1:0]    slot_valid;
  logic                wr_en, ovf_d;
  logic [SW-1:0]       wr_slot;
  int                  free_idx;

  assign free_idx = mcba_pkg::lowest_zero(32'(slot_valid), NSLOT);
  assign wr_en    = need && !all_win && (free_idx < NSLOT);
  assign ovf_d    = need && !all_win && (free_idx >= NSLOT);
  assign wr_slot  = SW'(free_idx);

  mcba_slot_table #(.NP(NP), .NSLOT(NSLOT)) i_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_flat   (clr_flat),
    .wr_en      (wr_en),
    .wr_slot    (wr_slot),
    .wr_mask    (la_mask),
    .rem_flat   (rem_flat),
    .slot_valid (slot_valid)
  );

  // per-output-port round-robin among held slots
  logic [NP-1:0]    gnt_any;
  logic [SW-1:0]    gnt_idx [NP];
  logic [NP*SW-1:0] slot_sel_d;

  genvar p, s;
  generate
    for (p = 0; p < NP; p++) begin : g_port
      logic [NSLOT-1:0] arb_req;
      for (s = 0; s < NSLOT; s++) begin : g_req
        assign arb_req[s]           = rem_flat[s*NP + p] & avail_buf[p];
        assign clr_flat[s*NP + p]   = gnt_any[p] && (int'(gnt_idx[p]) == s);
      end
      mcba_rr_arb #(.N(NSLOT)) i_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (arb_req),
        .gnt_any (gnt_any[p]),
        .gnt_idx (gnt_idx[p])
      );
      assign slot_sel_d[p*SW +: SW] = gnt_any[p] ? gnt_idx[p] : '0;
    end
  endgenerate

  // registered crossbar and buffer controls, valid in the flit's cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byp_en      <= 1'b0;
      xb_bypass   <= '0;
      xb_valid    <= '0;
      xb_slot     <= '0;
      buf_wr      <= 1'b0;
      buf_wr_slot <= '0;
      ovf_err     <= 1'b0;
    end else begin
      byp_en      <= all_win;
      xb_bypass   <= la_win_mask;
      xb_valid    <= la_win_mask | gnt_any;
      xb_slot     <= slot_sel_d;
      buf_wr      <= wr_en;
      buf_wr_slot <= wr_en ? wr_slot : '0;
      ovf_err     <= ovf_d;
    end
  end

  // ---------------- assertions ----------------
  assert_idle_la_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!la_valid || la_mask == '0) |=> (!byp_en && !buf_wr && !ovf_err));
  assert_bypass_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (la_valid && la_mask != '0 && (la_mask & ~out_avail) == '0)
    |=> (byp_en && xb_bypass == $past(la_mask)));
  assert_no_wr_on_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(byp_en && buf_wr));
  assert_partial_buffers_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (la_valid && (la_mask & ~out_avail) != '0)
    |=> (!byp_en && xb_bypass == '0 && (buf_wr || ovf_err)));
  assert_la_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_any & la_win_mask) == '0);
  assert_avail_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xb_valid & ~$past(out_avail)) == '0);
  assert_ovf_no_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |-> !buf_wr);
  assert_ovf_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_d |-> ($countones(slot_valid) == NSLOT));
endmodule

// File: tb/test_mcast_bypass_alloc.sv
`timescale 1ns/1ps
module test_mcast_bypass_alloc;
  localparam int NP = 5;
  localparam int NS = 4;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic la_valid;
  logic [NP-1:0] la_mask, out_avail;
  logic byp_en, buf_wr, ovf_err;
  logic [NP-1:0] xb_bypass, xb_valid;
  logic [NP*SW-1:0] xb_slot;
  logic [SW-1:0] buf_wr_slot;

  always #4 clk = ~clk;

  mcast_bypass_alloc i_mcast_bypass_alloc (
    .clk(clk), .rst_n(rst_n), .la_valid(la_valid), .la_mask(la_mask),
    .out_avail(out_avail), .byp_en(byp_en), .xb_bypass(xb_bypass),
    .xb_valid(xb_valid), .xb_slot(xb_slot), .buf_wr(buf_wr),
    .buf_wr_slot(buf_wr_slot), .ovf_err(ovf_err)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  int mrem [NS];
  int mptr [NP];
  // expected outputs for the next cycle
  logic e_byp, e_wr, e_ovf;
  logic [NP-1:0] e_xbb, e_xbv;
  logic [NP*SW-1:0] e_slot;
  logic [SW-1:0] e_wrslot;
  int n_byp = 0, n_ovf = 0, n_wr = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_step(input logic v, input logic [NP-1:0] m, input logic [NP-1:0] av);
    logic need, allwin;
    logic [NP-1:0] avb;
    int clr [NS];
    int fr;
    need   = v && (m != 0);
    allwin = need && ((m & ~av) == 0);
    e_byp  = allwin;
    e_xbb  = allwin ? m : '0;
    e_xbv  = e_xbb;
    e_slot = '0;
    avb    = av & ~e_xbb;
    foreach (clr[i]) clr[i] = 0;
    for (int p = 0; p < NP; p++) begin
      bit found = 0;
      if (avb[p]) begin
        for (int k = 0; k < NS; k++) begin
          int s = (mptr[p] + k) % NS;
          if (!found && ((mrem[s] >> p) & 1) == 1) begin
            found = 1;
            e_xbv[p] = 1'b1;
            e_slot[p*SW +: SW] = SW'(s);
            clr[s] |= (1 << p);
            mptr[p] = (s + 1) % NS;
          end
        end
      end
    end
    fr = NS;
    for (int s = NS - 1; s >= 0; s--) if (mrem[s] == 0) fr = s;
    e_wr     = need && !allwin && (fr < NS);
    e_ovf    = need && !allwin && (fr == NS);
    e_wrslot = e_wr ? SW'(fr) : '0;
    for (int s = 0; s < NS; s++) mrem[s] &= ~clr[s];
    if (e_wr) mrem[fr] = int'(m);
  endtask

  task automatic compare_all();
    chk("R3", "byp_en", int'(byp_en), int'(e_byp));
    chk("R5", "xb_bypass", int'(xb_bypass), int'(e_xbb));
    chk("R7", "xb_valid", int'(xb_valid), int'(e_xbv));
    chk("R8", "xb_slot", int'(xb_slot), int'(e_slot));
    chk("R5", "buf_wr/slot", int'({buf_wr, buf_wr_slot}), int'({e_wr, e_wrslot}));
    chk("R10", "ovf_err", int'(ovf_err), int'(e_ovf));
    // R4: bypass and buffer write never together
    chk("R4", "byp_and_wr", int'(byp_en && buf_wr), 0);
  endtask

  initial begin
    rst_n = 1'b0; la_valid = 1'b0; la_mask = '0; out_avail = '0;
    foreach (mrem[i]) mrem[i] = 0;
    foreach (mptr[i]) mptr[i] = 0;
    e_byp = 0; e_wr = 0; e_ovf = 0; e_xbb = 0; e_xbv = 0; e_slot = 0; e_wrslot = 0;
    la_valid = 1'b1; la_mask = '1; out_avail = '1;   // ignored under reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "outputs in reset", int'({byp_en, xb_bypass, xb_valid, xb_slot, buf_wr, buf_wr_slot, ovf_err}), 0);
    la_valid = 1'b0; la_mask = '0; out_avail = '0;
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      logic v;
      logic [NP-1:0] m, av;
      @(negedge clk);
      compare_all();
      if (byp_en) n_byp++;
      if (ovf_err) n_ovf++;
      if (buf_wr) n_wr++;
      v  = 1'b0; m = '0; av = '0;
      if (cyc < 3) begin
        // R1: nothing driven right after reset
      end else if (cyc < 20) begin
        // R2: masked or empty lookaheads have no effect
        v  = cyc[0];
        m  = cyc[0] ? '0 : NP'($urandom);
        av = NP'($urandom);
      end else if (cyc < 400) begin
        v  = ($urandom % 2) == 0;
        m  = NP'($urandom);
        av = NP'($urandom);
      end else if (cyc < 700) begin
        // R3/R6: broadcast with full availability, mixed with held traffic
        v  = 1'b1;
        m  = (($urandom % 3) == 0) ? NP'($urandom) : '1;
        av = (($urandom % 4) == 0) ? NP'($urandom) : '1;
      end else if (cyc < 1100) begin
        // R10: scarce ports fill the buffer
        v  = 1'b1;
        m  = NP'($urandom) | NP'(1);
        av = NP'($urandom) & NP'($urandom) & NP'($urandom);
      end else if (cyc < 1200) begin
        // R8: drain, multicast slots leave over several cycles
        v  = 1'b0;
        av = NP'($urandom);
      end else begin
        v  = ($urandom % 3) != 0;
        m  = NP'($urandom);
        av = NP'($urandom) | NP'($urandom);
      end
      la_valid = v; la_mask = m; out_avail = av;
      model_step(v, m, av);
    end
    @(negedge clk);
    compare_all();
    // stimulus coverage sanity (R3, R5, R10 all reached)
    chk("R3", "bypass seen", int'(n_byp > 0), 1);
    chk("R5", "buffer write seen", int'(n_wr > 0), 1);
    chk("R10", "overflow seen", int'(n_ovf > 0), 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule